// File: doc/BRIEF.md
# PMIC Arbiter Command Sequencer

This block runs one register transaction at a time against a memory-mapped PMIC arbiter channel. A host request gives a direction (read or write), an 8-bit serial-bus command code, a 4-bit slave id, a 16-bit register address, a length of 1 to 8 bytes and up to 8 bytes of write data. The sequencer first checks the request. It translates the command code into a 5-bit arbiter opcode and packs a 32-bit command word. It then performs the channel register accesses in the order the arbiter needs, polls the status register at a fixed interval, and returns a result code. A read also returns the data it fetched.

The register side is a simple single-beat master. The block holds `bus_req` and its address, direction and data until it samples `bus_ack` high on a rising edge. For a read, the data arrives on `bus_rdata` in that same cycle. While a transaction is open, `busy` is high and new requests are dropped. This gives each transaction exclusive use of the channel.

Top module: `spmi_cmd_engine`

## Requirements
- R1: For a read, codes 0x60..0x7F give opcode 15, codes 0x20..0x2F give opcode 13, and codes 0x38..0x3F give opcode 1. Any other read code ends with result 1 (invalid), makes no register access, and returns zero read data.
- R2: For a write, codes 0x40..0x5F give opcode 14, codes 0x00..0x0F give opcode 2, codes 0x30..0x37 give opcode 0, and codes 0x80..0xFF give opcode 16. Any other write code ends with result 1 and makes no register access.
- R3: A length of 0, or above 8, ends with result 1 and no register access. The result pulse comes in the cycle after the request is accepted.
- R4: The command word is written to offset 0x00. It holds the opcode in bits 31:27, the slave id in bits 23:20, the address in bits 19:4 and the length minus one in bits 2:0. All other bits are zero.
- R5: A write first stores data word 0 at offset 0x08. It stores data word 1 at offset 0x10 only when the length exceeds 4. The command comes last. Byte n of the request sits in lane n mod 4 of word n/4, and lanes at or beyond the length are zero.
- R6: A read writes the command first, then polls status. After a successful completion it reads offset 0x08, and then offset 0x10 if the length exceeds 4. The returned data places word 0 in bits 31:0 and word 1 in bits 63:32, with bytes at or beyond the length set to zero.
- R7: Status is read at offset 0x04. Bit 0 is done, bit 1 is failure, bit 2 is denied and bit 3 is dropped. Error bits are ignored while done is clear. When done is set, denied gives result 2; otherwise failure or dropped gives result 3; otherwise the result is 0 (success).
- R8: Successive status reads are at least CYCLES_PER_US+1 cycles apart. After POLL_LIMIT status reads without done, the transaction ends with result 4 (timeout) and makes no further access.
- R9: `busy` is high from acceptance until the result pulse. Requests offered while busy are ignored. `resp_valid` is a single-cycle pulse.
- R10: After reset, `busy`, `bus_req` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered; taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 8 | Serial-bus command code |
| req_sid | input | 4 | Slave id |
| req_addr | input | 16 | Register address |
| req_len | input | LEN_W (4) | Byte count, 1..8 legal |
| req_wdata | input | 64 | Write bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| resp_valid | output | 1 | Result pulse |
| resp_code | output | 3 | 0 ok, 1 invalid, 2 denied, 3 I/O error, 4 timeout |
| resp_rdata | output | 64 | Read bytes, valid with resp_valid |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 8 | Channel register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes on this edge |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The bench goes after the edges of every code range. A decoder off by one at 0x2F/0x30 or 0x37/0x38 would send the wrong opcode, or would reach the bus with a code it should reject. It drives lengths 0, 4, 5, 8 and 9. A wrong lane mask leaks stale bytes, and a wrong length-over-4 test skips the second data word or touches it when it should not. Status combinations such as denied with failure, or error bits shown before done, check the priority. An engine that read errors early would end on the first poll. A timeout run and a request offered mid-transaction check the poll bound and the exclusion.

// File: rtl/spmi_eng_pkg.sv
package spmi_eng_pkg;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_INVAL   = 3'd1,
    RES_PERM    = 3'd2,
    RES_IO      = 3'd3,
    RES_TIMEOUT = 3'd4
  } result_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WD0,
    ST_WD1,
    ST_CMD,
    ST_STAT,
    ST_WAIT,
    ST_RD0,
    ST_RD1
  } eng_state_t;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_D0   = 8'h08;
  localparam logic [7:0] OFS_D1   = 8'h10;

endpackage

// File: rtl/spmi_op_map.sv
module spmi_op_map
  import spmi_eng_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             is_write,
  input  logic [7:0]       code,
  input  logic [LEN_W-1:0] len,
  output logic [4:0]       opcode,
  output logic             legal
);

  logic code_ok;

  always_comb begin
    opcode  = 5'd0;
    code_ok = 1'b1;
    if (is_write) begin
      if (code >= 8'h40 && code <= 8'h5F)      opcode = 5'd14;
      else if (code <= 8'h0F)                  opcode = 5'd2;
      else if (code >= 8'h30 && code <= 8'h37) opcode = 5'd0;
      else if (code >= 8'h80)                  opcode = 5'd16;
      else                                     code_ok = 1'b0;
    end else begin
      if (code >= 8'h60 && code <= 8'h7F)      opcode = 5'd15;
      else if (code >= 8'h20 && code <= 8'h2F) opcode = 5'd13;
      else if (code >= 8'h38 && code <= 8'h3F) opcode = 5'd1;
      else                                     code_ok = 1'b0;
    end
  end

  assign legal = code_ok && (len != '0) && (int'(len) <= MAX_BYTES);

endmodule

// File: rtl/spmi_cmd_format.sv
module spmi_cmd_format #(
  parameter int MAX_BYTES = 8,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic [4:0]       opcode,
  input  logic [3:0]       sid,
  input  logic [15:0]      addr,
  input  logic [LEN_W-1:0] len,
  output logic [31:0]      cmd_word
);

  logic [LEN_W-1:0] len_m1;
  assign len_m1 = len - 1'b1;

  assign cmd_word = {opcode, 3'b000, sid, addr, 1'b0, len_m1[2:0]};

endmodule

// File: rtl/spmi_lane_mask.sv
module spmi_lane_mask #(
  parameter int MAX_BYTES = 8,
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int DW = 8 * MAX_BYTES
) (
  input  logic [LEN_W-1:0] len,
  output logic [DW-1:0]    mask
);

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
    assign mask[8*i +: 8] = (int'(len) > i) ? 8'hFF : 8'h00;
  end

endmodule

// File: rtl/spmi_status_decode.sv
module spmi_status_decode
  import spmi_eng_pkg::*;
(
  input  logic [3:0] status,
  output logic       done,
  output result_t    result
);

  assign done = status[0];

  always_comb begin
    if (status[2])      result = RES_PERM;
    else if (status[1]) result = RES_IO;
    else if (status[3]) result = RES_IO;
    else                result = RES_OK;
  end

endmodule

// File: rtl/spmi_cmd_engine.sv
module spmi_cmd_engine
  import spmi_eng_pkg::*;
#(
  parameter int MAX_BYTES     = 8,
  parameter int CYCLES_PER_US = 250,
  parameter int POLL_LIMIT    = 100,
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int DW    = 8 * MAX_BYTES,
  localparam int PC_W  = $clog2(POLL_LIMIT + 1),
  localparam int WC_W  = $clog2(CYCLES_PER_US + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_code,
  input  logic [3:0]       req_sid,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [DW-1:0]    req_wdata,
  output logic             busy,
  output logic             resp_valid,
  output logic [2:0]       resp_code,
  output logic [DW-1:0]    resp_rdata,
  output logic             bus_req,
  output logic             bus_we,
  output logic [7:0]       bus_addr,
  output logic [31:0]      bus_wdata,
  input  logic             bus_ack,
  input  logic [31:0]      bus_rdata
);

  eng_state_t       state;
  logic [4:0]       opcode;
  logic             legal;
  logic [31:0]      cmd_word;
  logic [DW-1:0]    in_mask;
  logic             st_done;
  result_t          st_result;

  logic             wr_q;
  logic             hi_q;
  logic [31:0]      cmd_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    mask_q;
  logic [DW-1:0]    rdata_q;
  logic [PC_W-1:0]  poll_cnt;
  logic [WC_W-1:0]  wait_cnt;
  result_t          code_q;

  spmi_op_map #(.MAX_BYTES(MAX_BYTES)) u_map (
    .is_write (req_write),
    .code     (req_code),
    .len      (req_len),
    .opcode   (opcode),
    .legal    (legal)
  );

  spmi_cmd_format #(.MAX_BYTES(MAX_BYTES)) u_fmt (
    .opcode   (opcode),
    .sid      (req_sid),
    .addr     (req_addr),
    .len      (req_len),
    .cmd_word (cmd_word)
  );

  spmi_lane_mask #(.MAX_BYTES(MAX_BYTES)) u_mask (
    .len  (req_len),
    .mask (in_mask)
  );

  spmi_status_decode u_stat (
    .status (bus_rdata[3:0]),
    .done   (st_done),
    .result (st_result)
  );

  assign busy       = (state != ST_IDLE);
  assign resp_code  = code_q;
  assign resp_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      code_q     <= RES_OK;
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      wr_q       <= 1'b0;
      hi_q       <= 1'b0;
      cmd_q      <= '0;
      wdata_q    <= '0;
      mask_q     <= '0;
      rdata_q    <= '0;
      poll_cnt   <= '0;
      wait_cnt   <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q     <= req_write;
            hi_q     <= (int'(req_len) > 4);
            cmd_q    <= cmd_word;
            wdata_q  <= req_wdata & in_mask;
            mask_q   <= in_mask;
            rdata_q  <= '0;
            poll_cnt <= '0;
            if (!legal) begin
              resp_valid <= 1'b1;
              code_q     <= RES_INVAL;
            end else if (req_write) begin
              state     <= ST_WD0;
              bus_req   <= 1'b1;
              bus_we    <= 1'b1;
              bus_addr  <= OFS_D0;
              bus_wdata <= req_wdata[31:0] & in_mask[31:0];
            end else begin
              state     <= ST_CMD;
              bus_req   <= 1'b1;
              bus_we    <= 1'b1;
              bus_addr  <= OFS_CMD;
              bus_wdata <= cmd_word;
            end
          end
        end
        ST_WD0: begin
          if (bus_ack) begin
            bus_we <= 1'b1;
            if (hi_q) begin
              state     <= ST_WD1;
              bus_addr  <= OFS_D1;
              bus_wdata <= wdata_q[63:32];
            end else begin
              state     <= ST_CMD;
              bus_addr  <= OFS_CMD;
              bus_wdata <= cmd_q;
            end
          end
        end
        ST_WD1: begin
          if (bus_ack) begin
            state     <= ST_CMD;
            bus_addr  <= OFS_CMD;
            bus_wdata <= cmd_q;
          end
        end
        ST_CMD: begin
          if (bus_ack) begin
            state     <= ST_STAT;
            bus_we    <= 1'b0;
            bus_addr  <= OFS_STAT;
            bus_wdata <= '0;
          end
        end
        ST_STAT: begin
          if (bus_ack) begin
            if (st_done) begin
              if (st_result != RES_OK || wr_q) begin
                state      <= ST_IDLE;
                bus_req    <= 1'b0;
                resp_valid <= 1'b1;
                code_q     <= st_result;
              end else begin
                state    <= ST_RD0;
                bus_addr <= OFS_D0;
              end
            end else if (int'(poll_cnt) == POLL_LIMIT - 1) begin
              state      <= ST_IDLE;
              bus_req    <= 1'b0;
              resp_valid <= 1'b1;
              code_q     <= RES_TIMEOUT;
            end else begin
              state    <= ST_WAIT;
              bus_req  <= 1'b0;
              poll_cnt <= poll_cnt + 1'b1;
              wait_cnt <= WC_W'(CYCLES_PER_US - 1);
            end
          end
        end
        ST_WAIT: begin
          if (wait_cnt == '0) begin
            state    <= ST_STAT;
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= OFS_STAT;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        ST_RD0: begin
          if (bus_ack) begin
            rdata_q[31:0] <= bus_rdata & mask_q[31:0];
            if (hi_q) begin
              state    <= ST_RD1;
              bus_addr <= OFS_D1;
            end else begin
              state      <= ST_IDLE;
              bus_req    <= 1'b0;
              resp_valid <= 1'b1;
              code_q     <= RES_OK;
            end
          end
        end
        ST_RD1: begin
          if (bus_ack) begin
            rdata_q[63:32] <= bus_rdata & mask_q[63:32];
            state      <= ST_IDLE;
            bus_req    <= 1'b0;
            resp_valid <= 1'b1;
            code_q     <= RES_OK;
          end
        end
        default: begin
          state   <= ST_IDLE;
          bus_req <= 1'b0;
        end
      endcase
    end
  end

  // R9: no register access while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !bus_req);

  // R9: result is a single-cycle pulse
  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R5: an access is held steady until acknowledged
  p_hold_access_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R3: rejected requests answer next cycle with no access
  p_reject_nobus_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !legal) |=> (resp_valid && resp_code == RES_INVAL && !bus_req));

  // R8: poll counter stays inside its bound
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (rst)
    int'(poll_cnt) < POLL_LIMIT);

  // R7: a status without done never ends the transaction with an error code
  p_err_needs_done_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STAT && bus_ack && !bus_rdata[0]) |=> (!resp_valid || resp_code == RES_TIMEOUT));

  // R4: reserved command bits are zero on the command write
  p_cmd_reserved_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == OFS_CMD) |-> (bus_wdata[26:24] == 3'b000 && !bus_wdata[3]));

endmodule

// File: tb/spmi_cmd_engine_tb.sv
module spmi_cmd_engine_tb;

  localparam int CPU   = 3;
  localparam int PLIM  = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_code = '0;
  logic [3:0]  req_sid = '0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        busy, resp_valid;
  logic [2:0]  resp_code;
  logic [63:0] resp_rdata;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  spmi_cmd_engine #(.CYCLES_PER_US(CPU), .POLL_LIMIT(PLIM)) u_dut (
    .clk, .rst, .req_valid, .req_write, .req_code, .req_sid, .req_addr,
    .req_len, .req_wdata, .busy, .resp_valid, .resp_code, .resp_rdata,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata
  );

  always #2 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int resp_cnt = 0;
  int dly = 0;
  int nst = 0;
  int log_n = 0;
  logic [7:0]  log_addr [0:255];
  logic        log_we   [0:255];
  logic [31:0] log_data [0:255];
  int          log_cyc  [0:255];
  int          cfg_nd = 0;
  logic [2:0]  cfg_err = '0;
  logic [31:0] cfg_w0 = '0, cfg_w1 = '0;

  // register slave model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (resp_valid) resp_cnt <= resp_cnt + 1;
    bus_ack <= 1'b0;
    if (!rst && bus_req && !bus_ack) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        bus_ack <= 1'b1;
        dly <= int'($urandom_range(0, 2));
        if (log_n < 256) begin
          log_addr[log_n] <= bus_addr;
          log_we[log_n]   <= bus_we;
          log_data[log_n] <= bus_wdata;
          log_cyc[log_n]  <= cyc;
        end
        log_n <= log_n + 1;
        case (bus_addr)
          8'h04: begin
            bus_rdata <= {28'h0, cfg_err, (nst >= cfg_nd)};
            nst <= nst + 1;
          end
          8'h08:   bus_rdata <= cfg_w0;
          8'h10:   bus_rdata <= cfg_w1;
          default: bus_rdata <= $urandom;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_op(input bit wr, input logic [7:0] c);
    if (wr) begin
      if (c >= 8'h40 && c <= 8'h5F) return 5'd14;
      if (c <= 8'h0F) return 5'd2;
      if (c >= 8'h30 && c <= 8'h37) return 5'd0;
      if (c >= 8'h80) return 5'd16;
    end else begin
      if (c >= 8'h60 && c <= 8'h7F) return 5'd15;
      if (c >= 8'h20 && c <= 8'h2F) return 5'd13;
      if (c >= 8'h38 && c <= 8'h3F) return 5'd1;
    end
    return 5'd31;
  endfunction

  function automatic logic [63:0] ref_mask(input int len);
    logic [63:0] m = '0;
    for (int i = 0; i < 8; i++) if (i < len) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk_entry(input int k, input bit we, input logic [7:0] a,
                           input bit cd, input logic [31:0] d, input string req);
    chk(log_we[k] == we && log_addr[k] == a, req, $sformatf("access %0d we/addr", k),
        {55'h0, log_we[k], log_addr[k]}, {55'h0, we, a});
    if (cd) chk(log_data[k] == d, req, $sformatf("access %0d data", k), 64'(log_data[k]), 64'(d));
  endtask

  task automatic txn(input bit wr, input logic [7:0] code, input logic [3:0] sid,
                     input logic [15:0] addr, input int len, input logic [63:0] wd,
                     input int nd, input logic [2:0] err, input bit poke);
    logic [4:0]  op;
    bit          legal;
    int          k, nstat, ec, rc0, n, lg;
    logic [31:0] cmdw;
    logic [63:0] m, exp_rd;
    @(negedge clk);
    cfg_nd = nd; cfg_err = err; cfg_w0 = $urandom; cfg_w1 = $urandom;
    nst = 0; log_n = 0;
    rc0 = resp_cnt;
    req_valid = 1'b1; req_write = wr; req_code = code; req_sid = sid;
    req_addr = addr; req_len = 4'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!resp_valid && n < 6000) begin
      if (poke && n == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_code = 8'h40; req_len = 4'd1;
      end else req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    op = ref_op(wr, code);
    legal = (op != 5'd31) && len >= 1 && len <= 8;
    m = ref_mask(len);
    cmdw = {op, 3'b000, sid, addr, 1'b0, 3'(len - 1)};
    nstat = (nd >= PLIM) ? PLIM : nd + 1;
    if (nd >= PLIM) ec = 4;
    else if (err[1]) ec = 2;
    else if (err[0] || err[2]) ec = 3;
    else ec = 0;
    if (!legal) ec = 1;
    chk(resp_valid == 1'b1, "R9", "result pulse seen", 64'(resp_valid), 64'd1);
    chk(int'(resp_code) == ec, (ec == 1) ? (wr ? "R2/R3" : "R1/R3") : (ec == 4 ? "R8" : "R7"),
        "result code", 64'(resp_code), 64'(ec));
    exp_rd = (legal && !wr && ec == 0) ? ({cfg_w1, cfg_w0} & m) : 64'h0;
    if (len <= 4) exp_rd[63:32] = 32'h0;
    chk(resp_rdata == exp_rd, "R6", "read data", resp_rdata, exp_rd);
    lg = log_n;
    if (!legal) begin
      chk(lg == 0, "R3", "no access on reject", 64'(lg), 64'd0);
    end else begin
      k = 0;
      if (wr) begin
        chk_entry(k, 1'b1, 8'h08, 1'b1, wd[31:0] & m[31:0], "R5"); k++;
        if (len > 4) begin chk_entry(k, 1'b1, 8'h10, 1'b1, wd[63:32] & m[63:32], "R5"); k++; end
        chk_entry(k, 1'b1, 8'h00, 1'b1, cmdw, "R4"); k++;
      end else begin
        chk_entry(k, 1'b1, 8'h00, 1'b1, cmdw, "R4"); k++;
      end
      for (int j = 0; j < nstat; j++) begin
        chk_entry(k, 1'b0, 8'h04, 1'b0, 32'h0, "R7");
        if (j > 0)
          chk(log_cyc[k] - log_cyc[k-1] >= CPU + 1, "R8", "poll spacing",
              64'(log_cyc[k] - log_cyc[k-1]), 64'(CPU + 1));
        k++;
      end
      if (!wr && ec == 0) begin
        chk_entry(k, 1'b0, 8'h08, 1'b0, 32'h0, "R6"); k++;
        if (len > 4) begin chk_entry(k, 1'b0, 8'h10, 1'b0, 32'h0, "R6"); k++; end
      end
      chk(lg == k, (ec == 4) ? "R8" : (wr ? "R5" : "R6"), "access count", 64'(lg), 64'(k));
    end
    repeat (8) @(negedge clk);
    chk(resp_cnt - rc0 == 1, "R9", "one result per request", 64'(resp_cnt - rc0), 64'd1);
    chk(log_n == lg, "R9", "no access after result", 64'(log_n), 64'(lg));
    chk(busy == 1'b0, "R9", "busy clear after result", 64'(busy), 64'd0);
  endtask

  initial begin
    #(4 * 190000);
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && bus_req == 0 && resp_valid == 0, "R10", "reset state",
        {61'h0, busy, bus_req, resp_valid}, 64'h0);

    // R1 read range edges
    txn(0, 8'h60, 4'h3, 16'h1234, 1, 0, 0, 0, 0);
    txn(0, 8'h7F, 4'hF, 16'hFFFF, 8, 0, 1, 0, 0);
    txn(0, 8'h2F, 4'h1, 16'h0042, 5, 0, 0, 0, 0);
    txn(0, 8'h38, 4'h2, 16'h8001, 4, 0, 0, 0, 0);
    txn(0, 8'h30, 4'h2, 16'h8001, 4, 0, 0, 0, 0);
    txn(0, 8'h1F, 4'h2, 16'h8001, 2, 0, 0, 0, 0);
    // R2 write range edges
    txn(1, 8'h0F, 4'h4, 16'hABCD, 3, 64'h1122334455667788, 0, 0, 0);
    txn(1, 8'h37, 4'h5, 16'h0001, 8, 64'hA1B2C3D4E5F60718, 0, 0, 0);
    txn(1, 8'h80, 4'h6, 16'h0100, 5, 64'hFFFFFFFFFFFFFFFF, 2, 0, 0);
    txn(1, 8'h5F, 4'h7, 16'h0200, 4, 64'hFFFFFFFFFFFFFFFF, 0, 0, 0);
    txn(1, 8'h38, 4'h7, 16'h0200, 4, 64'h0, 0, 0, 0);
    txn(1, 8'h7F, 4'h7, 16'h0200, 4, 64'h0, 0, 0, 0);
    // R3 length edges
    txn(1, 8'h40, 4'h1, 16'h0010, 0, 64'h5, 0, 0, 0);
    txn(0, 8'h60, 4'h1, 16'h0010, 9, 64'h5, 0, 0, 0);
    // R7 priority and early error bits
    txn(0, 8'h60, 4'h1, 16'h0011, 2, 0, 0, 3'b011, 0);
    txn(1, 8'h40, 4'h1, 16'h0011, 2, 64'h77, 0, 3'b101, 0);
    txn(1, 8'h40, 4'h1, 16'h0011, 2, 64'h77, 0, 3'b100, 0);
    txn(0, 8'h20, 4'h1, 16'h0011, 6, 0, 3, 3'b000, 0);
    // R8 timeout
    txn(0, 8'h61, 4'h9, 16'h0F0F, 2, 0, 150, 3'b111, 0);
    // R9 request offered while busy
    txn(1, 8'h41, 4'h9, 16'h0F0F, 6, 64'hDEADBEEFCAFEF00D, 4, 0, 1);

    for (int t = 0; t < 70; t++) begin
      bit wr = 1'($urandom % 2);
      logic [7:0] code = 8'($urandom);
      int len = ($urandom % 6 == 0) ? int'($urandom % 16) : int'($urandom % 8) + 1;
      int nd = ($urandom % 14 == 0) ? 150 : int'($urandom % 4);
      logic [2:0] err = ($urandom % 2) ? 3'($urandom) : 3'b000;
      if ($urandom % 5 != 0) begin
        case ({wr, 2'($urandom % 4)})
          3'b000:  code = 8'h60 + 8'($urandom % 32);
          3'b001:  code = 8'h20 + 8'($urandom % 16);
          3'b010:  code = 8'h38 + 8'($urandom % 8);
          3'b011:  code = 8'h60 + 8'($urandom % 32);
          3'b100:  code = 8'h40 + 8'($urandom % 32);
          3'b101:  code = 8'($urandom % 16);
          3'b110:  code = 8'h30 + 8'($urandom % 8);
          default: code = 8'h80 + 8'($urandom % 128);
        endcase
      end
      txn(wr, code, 4'($urandom), 16'($urandom), len, {$urandom, $urandom}, nd, err, 0);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule